// File: doc/BRIEF.md
# Instruction Cycle Cost and Effective Address Unit

This block works out the clock-cycle cost of one instruction of an 8-bit accumulator processor, together with the effective address that the instruction uses. An external decoder supplies four things: a base cycle count, an addressing-mode code, a flag that marks the access as read-only, and the operands. The operands are a base address, an index byte and, for branches, a taken flag, a signed 8-bit displacement and the address of the following instruction. The block does not fetch, decode or touch memory.

The cost of an indexed read rises by one cycle when adding the index moves the address onto another 256-byte page. Stores and read-modify-write operations already include that cycle in their base count, so they take no extra cycle. A branch that is taken costs one extra cycle, or two if its target lies on another page. Zero-page indexed forms wrap inside page zero. The results appear one clock after a start strobe, together with a one-cycle valid pulse.

Top module: `idx_cycle_cost`

## Requirements
- R1: While `rst` is high, and after it until the first strobe, `res_valid` is 0 and `res_cycles` and `res_addr` are 0.
- R2: `res_valid` is 1 in exactly the cycle after a cycle with `start` high, and 0 otherwise. The results of that strobe appear in the same cycle as the pulse.
- R3: Mode code 0 (direct) gives `res_addr` = `base_addr` and `res_cycles` = `base_cyc`, with no page penalty.
- R4: Mode codes 1, 2 and 3 (absolute indexed by X, absolute indexed by Y, pointer indexed by Y) give `res_addr` = (`base_addr` + `index_val`) mod 65536.
- R5: In modes 1, 2 and 3 with `rd_only` = 1, `res_cycles` = `base_cyc` + 1 when bits 15:8 of `base_addr` and of `res_addr` differ, and `base_cyc` when they are equal.
- R6: In modes 1, 2 and 3 with `rd_only` = 0, `res_cycles` = `base_cyc` whether or not a page is crossed.
- R7: Mode codes 4 and 5 (zero page indexed by X or Y) give `res_addr` = {8'h00, (`base_addr`[7:0] + `index_val`) mod 256} and `res_cycles` = `base_cyc`.
- R8: Mode code 6 (pointer indexed before the read) gives the pointer location {8'h00, (`base_addr`[7:0] + `index_val`) mod 256} and `res_cycles` = `base_cyc`.
- R9: Mode code 7 (branch) with `br_taken` = 0 gives `res_cycles` = 2 and `res_addr` = `pc_next`, and `base_cyc` has no effect.
- R10: Mode code 7 with `br_taken` = 1 gives `res_addr` = `pc_next` + sign-extended `br_disp` (mod 65536). `res_cycles` is 3 when bits 15:8 of target and `pc_next` match, and 4 otherwise.
- R11: A non-branch total that would exceed 15 saturates at 15.
- R12: In cycles without a strobe, `res_cycles` and `res_addr` keep their last values whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Strobe: evaluate the present inputs |
| base_cyc | input | 4 | Base cycle count from the decoder |
| mode | input | 3 | Addressing-mode code (0 to 7) |
| rd_only | input | 1 | 1 when the instruction only reads memory |
| base_addr | input | 16 | Operand address or pointer value |
| index_val | input | 8 | Index register value |
| br_taken | input | 1 | Branch condition met |
| br_disp | input | 8 | Signed branch displacement |
| pc_next | input | 16 | Address of the instruction after the branch |
| res_addr | output | 16 | Effective address, or branch target |
| res_cycles | output | 4 | Total cycle cost |
| res_valid | output | 1 | One-cycle pulse marking new results |

## Verification
Every result is due exactly one clock after its strobe. Inputs change on the falling edge with `start` high for one cycle. The bench samples address, cost and valid on the next falling edge, which follows the single register stage. On the falling edge after that, with the inputs scrambled, it checks that valid has dropped and that address and cost have not moved. The sweep covers every mode code, both access classes, and pairs that do and do not cross a page, including wraps at 16'hFFFF and inside page zero. It also covers branch targets reached by forward and backward displacements.

// File: rtl/cost_pkg.sv
package cost_pkg;
  typedef enum logic [2:0] {
    AM_DIRECT   = 3'd0,
    AM_ABS_X    = 3'd1,
    AM_ABS_Y    = 3'd2,
    AM_PTR_Y    = 3'd3,
    AM_ZP_X     = 3'd4,
    AM_ZP_Y     = 3'd5,
    AM_ZP_PTR_X = 3'd6,
    AM_BRANCH   = 3'd7
  } amode_t;

  function automatic logic is_far_indexed(amode_t m);
    return (m == AM_ABS_X) || (m == AM_ABS_Y) || (m == AM_PTR_Y);
  endfunction

  function automatic logic is_zp_wrapped(amode_t m);
    return (m == AM_ZP_X) || (m == AM_ZP_Y) || (m == AM_ZP_PTR_X);
  endfunction
endpackage

// File: rtl/addr_unit.sv
module addr_unit
  import cost_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8,
  parameter int PAGE_W = 8,
  parameter int DISP_W = 8
) (
  input  amode_t              mode,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [IDX_W-1:0]    index_val,
  input  logic                br_taken,
  input  logic [DISP_W-1:0]   br_disp,
  input  logic [ADDR_W-1:0]   pc_next,
  output logic [ADDR_W-1:0]   eff_addr,
  output logic [ADDR_W-1:0]   ref_addr
);
  logic [ADDR_W-1:0] far_sum;
  logic [PAGE_W-1:0] zp_sum;
  logic [ADDR_W-1:0] disp_ext;

  assign far_sum  = base_addr + ADDR_W'(index_val);
  assign zp_sum   = base_addr[PAGE_W-1:0] + PAGE_W'(index_val);
  assign disp_ext = {{(ADDR_W-DISP_W){br_disp[DISP_W-1]}}, br_disp};

  always_comb begin
    ref_addr = base_addr;
    eff_addr = base_addr;
    if (mode == AM_BRANCH) begin
      ref_addr = pc_next;
      eff_addr = br_taken ? pc_next + disp_ext : pc_next;
    end else if (is_far_indexed(mode)) begin
      eff_addr = far_sum;
    end else if (is_zp_wrapped(mode)) begin
      eff_addr = {{(ADDR_W-PAGE_W){1'b0}}, zp_sum};
    end
  end
endmodule

// File: rtl/page_cross.sv
module page_cross #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8
) (
  input  logic [ADDR_W-1:0] from_addr,
  input  logic [ADDR_W-1:0] to_addr,
  output logic              crossed
);
  logic [ADDR_W-1:0] diff;
  assign diff    = from_addr ^ to_addr;
  assign crossed = |diff[ADDR_W-1:PAGE_W];
endmodule

// File: rtl/cycle_total.sv
module cycle_total
  import cost_pkg::*;
#(
  parameter int CYC_W      = 4,
  parameter int BR_BASE    = 2
) (
  input  amode_t           mode,
  input  logic [CYC_W-1:0] base_cyc,
  input  logic             rd_only,
  input  logic             br_taken,
  input  logic             crossed,
  output logic [CYC_W-1:0] total
);
  localparam int SUM_W = CYC_W + 2;
  localparam logic [SUM_W-1:0] CYC_MAX = SUM_W'((1 << CYC_W) - 1);

  logic [SUM_W-1:0] sum;

  always_comb begin
    if (mode == AM_BRANCH) begin
      sum = SUM_W'(BR_BASE) + SUM_W'(br_taken) + SUM_W'(br_taken & crossed);
    end else begin
      sum = SUM_W'(base_cyc) + SUM_W'(is_far_indexed(mode) & rd_only & crossed);
    end
    total = (sum > CYC_MAX) ? CYC_MAX[CYC_W-1:0] : sum[CYC_W-1:0];
  end
endmodule

// File: rtl/idx_cycle_cost.sv
module idx_cycle_cost
  import cost_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8,
  parameter int PAGE_W = 8,
  parameter int DISP_W = 8,
  parameter int CYC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CYC_W-1:0]  base_cyc,
  input  logic [2:0]        mode,
  input  logic              rd_only,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [IDX_W-1:0]  index_val,
  input  logic              br_taken,
  input  logic [DISP_W-1:0] br_disp,
  input  logic [ADDR_W-1:0] pc_next,
  output logic [ADDR_W-1:0] res_addr,
  output logic [CYC_W-1:0]  res_cycles,
  output logic              res_valid
);
  amode_t            mode_e;
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] ref_addr;
  logic              crossed;
  logic [CYC_W-1:0]  total;

  assign mode_e = amode_t'(mode);

  addr_unit #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PAGE_W(PAGE_W), .DISP_W(DISP_W)
  ) u_addr (
    .mode(mode_e), .base_addr(base_addr), .index_val(index_val),
    .br_taken(br_taken), .br_disp(br_disp), .pc_next(pc_next),
    .eff_addr(eff_addr), .ref_addr(ref_addr)
  );

  page_cross #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_cross (
    .from_addr(ref_addr), .to_addr(eff_addr), .crossed(crossed)
  );

  cycle_total #(.CYC_W(CYC_W)) u_total (
    .mode(mode_e), .base_cyc(base_cyc), .rd_only(rd_only),
    .br_taken(br_taken), .crossed(crossed), .total(total)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_addr   <= '0;
      res_cycles <= '0;
      res_valid  <= 1'b0;
    end else begin
      res_valid <= start;
      if (start) begin
        res_addr   <= eff_addr;
        res_cycles <= total;
      end
    end
  end
endmodule

// File: rtl/idx_cycle_cost_chk.sv
module idx_cycle_cost_chk #(
  parameter int ADDR_W = 16,
  parameter int CYC_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [CYC_W-1:0]  base_cyc,
  input logic [2:0]        mode,
  input logic              rd_only,
  input logic [ADDR_W-1:0] res_addr,
  input logic [CYC_W-1:0]  res_cycles,
  input logic              res_valid
);
  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start |=> res_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !start |=> !res_valid); // R2
  AST_BRANCH_COST_RANGE: assert property (@(posedge clk) disable iff (rst)
    (start && mode == 3'd7) |=> (res_cycles >= 2 && res_cycles <= 4)); // R10
  AST_ZP_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
    (start && (mode == 3'd4 || mode == 3'd5 || mode == 3'd6))
      |=> (res_addr[ADDR_W-1:8] == '0)); // R7
  AST_WRITE_NO_PENALTY: assert property (@(posedge clk) disable iff (rst)
    (start && !rd_only && (mode == 3'd1 || mode == 3'd2 || mode == 3'd3))
      |=> (res_cycles == $past(base_cyc))); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(res_cycles) && $stable(res_addr))); // R12
endmodule

bind idx_cycle_cost idx_cycle_cost_chk #(.ADDR_W(ADDR_W), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .base_cyc(base_cyc), .mode(mode),
  .rd_only(rd_only), .res_addr(res_addr), .res_cycles(res_cycles),
  .res_valid(res_valid)
);

// File: tb/test_idx_cycle_cost.sv
module test_idx_cycle_cost;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  base_cyc = '0;
  logic [2:0]  mode = '0;
  logic        rd_only = 1'b0;
  logic [15:0] base_addr = '0;
  logic [7:0]  index_val = '0;
  logic        br_taken = 1'b0;
  logic [7:0]  br_disp = '0;
  logic [15:0] pc_next = '0;
  logic [15:0] res_addr;
  logic [3:0]  res_cycles;
  logic        res_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  idx_cycle_cost i_idx_cycle_cost (
    .clk(clk), .rst(rst), .start(start), .base_cyc(base_cyc), .mode(mode),
    .rd_only(rd_only), .base_addr(base_addr), .index_val(index_val),
    .br_taken(br_taken), .br_disp(br_disp), .pc_next(pc_next),
    .res_addr(res_addr), .res_cycles(res_cycles), .res_valid(res_valid)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_addr();
    int s;
    case (mode)
      3'd0: return base_addr;
      3'd1, 3'd2, 3'd3: return (base_addr + index_val) % 65536;
      3'd4, 3'd5, 3'd6: return (base_addr % 256 + index_val) % 256;
      default: begin
        s = br_disp[7] ? int'(br_disp) - 256 : int'(br_disp);
        return br_taken ? (pc_next + s + 65536) % 65536 : pc_next;
      end
    endcase
  endfunction

  function automatic int exp_cyc();
    int t;
    int a;
    a = exp_addr();
    if (mode == 3'd7) begin
      if (!br_taken) return 2;
      return ((a / 256) != (pc_next / 256)) ? 4 : 3;
    end
    t = base_cyc;
    if ((mode inside {3'd1, 3'd2, 3'd3}) && rd_only && ((a / 256) != (base_addr / 256)))
      t = t + 1;
    return (t > 15) ? 15 : t;
  endfunction

  function automatic string tag_of();
    case (mode)
      3'd0: return "R3";
      3'd1, 3'd2, 3'd3: return rd_only ? "R4/R5" : "R4/R6";
      3'd4, 3'd5: return "R7";
      3'd6: return "R8";
      default: return br_taken ? "R10" : "R9";
    endcase
  endfunction

  task automatic run_vec();
    int ea;
    int cy;
    string tg;
    ea = exp_addr();
    cy = exp_cyc();
    tg = tag_of();
    if (mode != 3'd7 && base_cyc == 4'd15) tg = {tg, "/R11"};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 valid", int'(res_valid), 1);
    check({tg, " addr"}, int'(res_addr), ea);
    check({tg, " cycles"}, int'(res_cycles), cy);
    base_addr = ~base_addr;
    index_val = ~index_val;
    base_cyc  = ~base_cyc;
    mode      = mode + 3'd3;
    br_taken  = ~br_taken;
    @(negedge clk);
    check("R2 idle", int'(res_valid), 0);
    check("R12 addr hold", int'(res_addr), ea);
    check("R12 cycles hold", int'(res_cycles), cy);
  endtask

  initial begin
    logic [15:0] bases [5] = '{16'h12F0, 16'h12F0, 16'hFFFF, 16'h0080, 16'h34FF};
    logic [7:0]  idxs  [5] = '{8'h0F, 8'h10, 8'h01, 8'h00, 8'hFF};
    logic [3:0]  cycs  [4] = '{4'd2, 4'd4, 4'd7, 4'd15};
    logic [15:0] pcs   [3] = '{16'h10F8, 16'h1008, 16'h0002};
    logic [7:0]  disps [4] = '{8'h7F, 8'h80, 8'h05, 8'hF0};
    repeat (3) @(negedge clk);
    check("R1 valid", int'(res_valid), 0);
    check("R1 addr", int'(res_addr), 0);
    check("R1 cycles", int'(res_cycles), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after release", int'(res_valid), 0);
    check("R1 cycles after release", int'(res_cycles), 0);
    for (int m = 0; m < 7; m++)
      for (int r = 0; r < 2; r++)
        for (int p = 0; p < 5; p++)
          for (int c = 0; c < 4; c++) begin
            mode = 3'(m); rd_only = r[0];
            base_addr = bases[p]; index_val = idxs[p];
            base_cyc = cycs[c]; br_taken = c[0];
            run_vec();
          end
    for (int p = 0; p < 3; p++)
      for (int d = 0; d < 4; d++)
        for (int t = 0; t < 2; t++) begin
          mode = 3'd7; pc_next = pcs[p]; br_disp = disps[d];
          br_taken = t[0]; base_cyc = 4'(d * 5); rd_only = t[0];
          base_addr = 16'h4321; index_val = 8'h99;
          run_vec();
        end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule